// File: doc/BRIEF.md
# Channel Segment Address Translator

This block turns a 40-bit system address into a channel-local memory address. It holds eight rule registers, one for each interleave range, and a 3-bit index picks the rule for each translation. Software loads the rules through a simple word-wide register port. The translation datapath then reads the chosen rule directly.

Each translation runs in two steps. First, the rule's 24-bit offset is subtracted from system address bits 39:16, modulo 2^24. Bits 15:0 pass through unchanged. Second, any subset of address bits 8, 7 and 6 that the rule's removal mask selects is squeezed out. The bits above each removed position move down one place, and zeros fill in at the top. The result is bits 36:6 of the compacted value. It is registered together with the rule's divide-by-3 flag and an error flag that marks an unsupported rule. Range matching, the later divide-by-three stage and DRAM mapping are handled by other blocks.

Top module: `chan_seg_xlate`

## Requirements
- R1: After reset, every rule register reads back as zero and `out_valid` is low.
- R2: Rule n (0 to 7) sits at byte address 80h + 4n and is read and written as one 32-bit word. The word layout is: bit 27 is the divide-by-3 flag, bits 26:24 are the removal mask, and bits 23:0 are the offset. A misaligned address, or an address outside 80h to 9Ch, reads as zero and ignores writes.
- R3: Bits 31:28 of every rule word read as zero, and writes to them are ignored.
- R4: Intermediate bits m[39:16] equal system address bits 39:16 minus the offset, modulo 2^24 (the subtraction wraps). Intermediate bits m[15:6] equal system address bits 15:6.
- R5: Mask bit 2 removes intermediate bit 8, mask bit 1 removes bit 7, and mask bit 0 removes bit 6. Each removal shifts every higher bit down one place and fills with zero from bit 39 downward. `out_mem_addr` carries bits 36:6 of the result.
- R6: A translation presented with `in_valid` high appears on the outputs one clock later with `out_valid` high. The result outputs hold their value in cycles that follow no valid input.
- R7: `out_div3` equals bit 27 of the rule used for the translation.
- R8: `out_err` is high when the pair (mask, flag) is not one of 000/0, 001/0, 011/0, 000/1 or 001/1. It is also high when offset bits 9:0 are nonzero. The address is still computed in both cases.
- R9: If a rule write lands in the same cycle as a translation that uses that rule, the translation uses the old rule contents. The new contents apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Translation request valid |
| in_rule | input | 3 | Rule index for this request |
| in_sys_addr | input | 40 | System address to translate |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_mem_addr | output | 31 | Memory address bits 36:6 |
| out_div3 | output | 1 | Divide-by-3 flag of the rule used |
| out_err | output | 1 | Unsupported rule configuration |

## Verification
The bench builds the block with its default parameters: eight rules, an 8-bit register address, a 40-bit system address and a 24-bit offset. At that size the bench can cover every one of the 16 mask/flag pairs. Each pair is combined with offsets that are clean, large, reserved-bit-dirty and wrapping, and the pairs are spread so that all eight rule slots are used. Addresses come from a shift-register generator plus fixed corner values that force the subtraction to wrap. Every result is compared with a bit-by-bit model of the compaction. Separate checks cover the register map edges, the reserved bits, output holding and a write that collides with a translation.

// File: rtl/cseg_pkg.sv
// Package: shared rule layout and legality check for the segment translator.
// Assumes the rule word fits in 32 bits, with the unused top bits reserved.
package cseg_pkg;
    localparam int OFS_W  = 24;
    localparam int RM_W   = 3;
    localparam int RULE_W = OFS_W + RM_W + 1;

    typedef struct packed {
        logic              div3;
        logic [RM_W-1:0]   mask;
        logic [OFS_W-1:0]  offset;
    } rule_t;

    // Report whether the mask / divide-by-3 pair is one of the supported ones.
    function automatic logic combo_ok(input rule_t r);
        case ({r.mask, r.div3})
            4'b0000, 4'b0010, 4'b0110, 4'b0001, 4'b0011: combo_ok = 1'b1;
            default:                                     combo_ok = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/cseg_rule_file.sv
// Module: rule register bank with word read/write port and a translation read port.
// Assumes byte addressing and word-aligned access; other addresses are inert.
module cseg_rule_file
    import cseg_pkg::*;
#(
    parameter int N_RULES = 8,
    parameter int AW      = 8,
    parameter int BASE    = 128,
    localparam int IDX_W  = $clog2(N_RULES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic [IDX_W-1:0] sel_idx,
    output rule_t            sel_rule
);
    logic [AW-1:0]    rel;
    logic             hit;
    logic [IDX_W-1:0] widx;
    rule_t            rules [N_RULES];

    // Decode the register address into a hit flag and a rule index.
    assign rel  = addr - AW'(BASE);
    assign hit  = (addr >= AW'(BASE)) && (int'(addr) < BASE + 4 * N_RULES)
                  && (addr[1:0] == 2'b00);
    assign widx = rel[IDX_W+1:2];

    // One register per rule; only the addressed one takes a write.
    for (genvar g = 0; g < N_RULES; g++) begin : g_rule
        rule_t r_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                r_q <= '0;
            else if (wr_en && hit && widx == IDX_W'(g))
                r_q <= rule_t'(wdata[RULE_W-1:0]);
        end
        assign rules[g] = r_q;
    end

    // Read mux: reserved bits and unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        if (hit)
            rdata = {{(32-RULE_W){1'b0}}, rules[widx]};
    end

    // Translation port sees register contents before any same-cycle write.
    assign sel_rule = rules[sel_idx];

    logic unused_bits;
    assign unused_bits = ^{rel, wdata[31:RULE_W]};
endmodule

// File: rtl/cseg_xlate_core.sv
// Module: combinational offset subtraction and interleave-bit compaction.
// Assumes the offset width equals the width of the address above CUT.
module cseg_xlate_core
    import cseg_pkg::*;
#(
    parameter int SA_W   = 40,
    parameter int CUT    = 16,
    parameter int MA_LO  = 6,
    parameter int MA_HI  = 36,
    parameter int RSV_W  = 10,
    localparam int MA_W  = MA_HI - MA_LO + 1
) (
    input  logic [SA_W-1:0] sys_addr,
    input  rule_t           rule,
    output logic [MA_W-1:0] mem_addr,
    output logic            err
);
    logic [SA_W-1:0] m;
    logic [SA_W-1:0] keep_mask;

    // Subtract the offset from the upper field, then drop the masked bits, highest first.
    always_comb begin
        m         = {(SA_W-CUT)'(sys_addr[SA_W-1:CUT] - rule.offset), sys_addr[CUT-1:0]};
        keep_mask = '0;
        for (int k = RM_W - 1; k >= 0; k--) begin
            if (rule.mask[k]) begin
                keep_mask = (SA_W'(1) << (MA_LO + k)) - SA_W'(1);
                m = ((m >> (MA_LO + k + 1)) << (MA_LO + k)) | (m & keep_mask);
            end
        end
    end

    // Select the output slice and flag unsupported rules.
    assign mem_addr = m[MA_HI:MA_LO];
    assign err      = !combo_ok(rule) || (|rule.offset[RSV_W-1:0]);

    logic unused_bits;
    assign unused_bits = ^{m[SA_W-1:MA_HI+1], m[MA_LO-1:0]};
endmodule

// File: rtl/chan_seg_xlate.sv
// Module: top of the channel segment translator; one-cycle registered result.
// Assumes the request is launched at most once per cycle; rule writes are word-wide.
module chan_seg_xlate
    import cseg_pkg::*;
#(
    parameter int N_RULES  = 8,
    parameter int REG_AW   = 8,
    parameter int REG_BASE = 128,
    parameter int SA_W     = 40,
    parameter int MA_LO    = 6,
    parameter int MA_HI    = 36,
    localparam int IDX_W   = $clog2(N_RULES),
    localparam int MA_W    = MA_HI - MA_LO + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_rule,
    input  logic [SA_W-1:0]   in_sys_addr,
    output logic              out_valid,
    output logic [MA_W-1:0]   out_mem_addr,
    output logic              out_div3,
    output logic              out_err
);
    rule_t           sel_rule;
    logic [MA_W-1:0] nxt_addr;
    logic            nxt_err;

    cseg_rule_file #(
        .N_RULES (N_RULES),
        .AW      (REG_AW),
        .BASE    (REG_BASE)
    ) u_rules (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .sel_idx  (in_rule),
        .sel_rule (sel_rule)
    );

    cseg_xlate_core #(
        .SA_W  (SA_W),
        .MA_LO (MA_LO),
        .MA_HI (MA_HI)
    ) u_core (
        .sys_addr (in_sys_addr),
        .rule     (sel_rule),
        .mem_addr (nxt_addr),
        .err      (nxt_err)
    );

    // Valid pipeline flag.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers: load on a valid request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_mem_addr <= '0;
            out_div3     <= 1'b0;
            out_err      <= 1'b0;
        end else if (in_valid) begin
            out_mem_addr <= nxt_addr;
            out_div3     <= sel_rule.div3;
            out_err      <= nxt_err;
        end
    end
endmodule

// File: rtl/cseg_xlate_chk.sv
// Module: property checker for chan_seg_xlate, attached by bind.
// Assumes the default address slice parameters of the top module.
module cseg_xlate_chk
    import cseg_pkg::*;
#(
    parameter int SA_W  = 40,
    parameter int MA_LO = 6,
    parameter int MA_HI = 36
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [SA_W-1:0]        in_sys_addr,
    input rule_t                  sel_rule,
    input logic                   out_valid,
    input logic [MA_HI-MA_LO:0]   out_mem_addr,
    input logic                   out_div3,
    input logic                   out_err,
    input logic [31:0]            reg_rdata
);
    // R6
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_mem_addr) && $stable(out_err) && $stable(out_div3));

    // R3
    rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:28] == 4'h0);

    // R8
    dirty_offset_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (|sel_rule.offset[9:0]) |=> out_err);

    // R8
    full_mask_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && sel_rule.mask == 3'b111 |=> out_err);

    // R5
    identity_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && sel_rule == '0 |=> out_mem_addr == $past(in_sys_addr[MA_HI:MA_LO]) && !out_err);

    // R7
    div3_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_div3 == $past(sel_rule.div3));
endmodule

bind chan_seg_xlate cseg_xlate_chk #(
    .SA_W  (SA_W),
    .MA_LO (MA_LO),
    .MA_HI (MA_HI)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_sys_addr  (in_sys_addr),
    .sel_rule     (sel_rule),
    .out_valid    (out_valid),
    .out_mem_addr (out_mem_addr),
    .out_div3     (out_div3),
    .out_err      (out_err),
    .reg_rdata    (reg_rdata)
);

// File: tb/chan_seg_xlate_test.sv
module chan_seg_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [2:0]  in_rule = '0;
    logic [39:0] in_sys_addr = '0;
    logic        out_valid;
    logic [30:0] out_mem_addr;
    logic        out_div3;
    logic        out_err;

    int vectors = 0;
    int misses  = 0;
    logic [31:0] shadow [8];
    logic [39:0] lfsr = 40'h5A_C3E1_9B27;

    always #5 clk = ~clk;

    chan_seg_xlate uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_rule(in_rule), .in_sys_addr(in_sys_addr), .out_valid(out_valid),
        .out_mem_addr(out_mem_addr), .out_div3(out_div3), .out_err(out_err)
    );

    // Bit-by-bit model of subtraction followed by compaction (R4, R5).
    function automatic logic [30:0] model_addr(logic [39:0] sa, logic [2:0] mk, logic [23:0] of);
        logic [39:0] m;
        logic [39:0] c;
        int p;
        m = {sa[39:16] - of, sa[15:0]};
        c = '0;
        p = 6;
        for (int j = 6; j < 40; j++) begin
            if (!((j == 6 && mk[0]) || (j == 7 && mk[1]) || (j == 8 && mk[2]))) begin
                c[p] = m[j];
                p++;
            end
        end
        return c[36:6];
    endfunction

    // Model of the error flag (R8).
    function automatic logic model_err(logic [2:0] mk, logic d, logic [23:0] of);
        logic ok;
        ok = (mk == 3'b000) || (mk == 3'b001) || (mk == 3'b011 && !d);
        return !ok || (of[9:0] != 10'd0);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a >= 8'h80 && a <= 8'h9C && a[1:0] == 2'b00)
            shadow[(a - 8'h80) >> 2] = {4'h0, d[27:0]};
    endtask

    task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, 64'(reg_rdata), 64'(exp));
    endtask

    // Apply one translation and check the registered result one cycle later.
    task automatic xl(logic [2:0] r, logic [39:0] sa);
        logic [31:0] w;
        w = shadow[r];
        @(negedge clk);
        in_valid = 1'b1; in_rule = r; in_sys_addr = sa;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4/R5", 64'(out_mem_addr), 64'(model_addr(sa, w[26:24], w[23:0])));
        check("R6/R7/R8", {61'd0, out_valid, out_div3, out_err},
              {61'd0, 1'b1, w[27], model_err(w[26:24], w[27], w[23:0])});
    endtask

    task automatic finish_up;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        logic [23:0] ofs [5];
        logic [30:0] held;
        ofs[0] = 24'h000000; ofs[1] = 24'h000400; ofs[2] = 24'hABCC00;
        ofs[3] = 24'hFFFC00; ofs[4] = 24'h000123;
        for (int i = 0; i < 8; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 out_valid", 64'(out_valid), 64'd0);
        for (int i = 0; i < 8; i++) rd("R1", 8'(8'h80 + 4 * i), 32'h0);

        // R3: reserved bits are dropped; R2: word layout per slot
        wr(8'h8C, 32'hFFFF_FFFF);
        rd("R3", 8'h8C, 32'h0FFF_FFFF);
        wr(8'h9C, 32'h1B12_3400);
        rd("R2", 8'h9C, 32'h0B12_3400);

        // R2: unmapped and misaligned addresses ignore writes and read zero
        wr(8'h7C, 32'h0123_4567);
        wr(8'hA0, 32'h0765_4321);
        wr(8'h81, 32'h0555_5555);
        rd("R2 low", 8'h7C, 32'h0);
        rd("R2 high", 8'hA0, 32'h0);
        rd("R2 misaligned", 8'h81, 32'h0);
        for (int i = 0; i < 8; i++) rd("R2 intact", 8'(8'h80 + 4 * i), shadow[i]);

        // Sweep all 16 mask/flag pairs against several offsets and addresses.
        for (int c = 0; c < 16; c++) begin
            for (int oi = 0; oi < 5; oi++) begin
                logic [2:0] r;
                r = 3'((c + oi) % 8);
                wr(8'(8'h80 + 4 * r), {4'h0, 1'(c & 1), 3'(c >> 1), ofs[oi]});
                for (int k = 0; k < 24; k++) begin
                    logic [39:0] sa;
                    lfsr = {lfsr[38:0], lfsr[39] ^ lfsr[37] ^ lfsr[20] ^ lfsr[18]};
                    sa = (k == 0) ? 40'h0 : (k == 1) ? {40{1'b1}} :
                         (k == 2) ? 40'h00_0000_FFC0 : (k == 3) ? 40'h00_03FF_FFFF : lfsr;
                    xl(r, sa);
                end
            end
        end

        // R6: outputs hold during an idle cycle
        held = out_mem_addr;
        @(negedge clk);
        in_sys_addr = 40'hFF_FFFF_FFFF; in_rule = 3'd2;
        @(negedge clk);
        check("R6 idle valid", 64'(out_valid), 64'd0);
        check("R6 hold", 64'(out_mem_addr), 64'(held));

        // R9: write colliding with a translation on the same rule
        wr(8'h94, {4'h0, 1'b0, 3'b001, 24'h000400});
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h94; reg_wdata = {4'h0, 1'b1, 3'b000, 24'h001000};
        in_valid = 1'b1; in_rule = 3'd5; in_sys_addr = 40'h12_3456_7890;
        @(negedge clk);
        reg_wr = 1'b0; in_valid = 1'b0;
        check("R9 old rule", 64'(out_mem_addr), 64'(model_addr(40'h12_3456_7890, 3'b001, 24'h000400)));
        check("R9 old flag", 64'(out_div3), 64'd0);
        shadow[5] = {4'h0, 1'b1, 3'b000, 24'h001000};
        xl(3'd5, 40'h12_3456_7890);

        finish_up();
    end
endmodule